// File: doc/BRIEF.md
# Decimating Waveform Capture with Coherent Byte Readout

This block sits beside a sample stream of signed 24-bit two's complement ADC words that arrive with a valid strobe at the full input rate (the master clock divided by 160). Every sample is forwarded unchanged to the downstream processing path one cycle later, and capture never stalls or drops that path. Alongside it, a decimator keeps one sample out of every 1, 2, 4 or 8 valid samples, as chosen by a 2-bit rate select. Each kept sample becomes the block's current capture and sets a sample-ready status bit.

A host reads the capture through a byte-wide port. A read of the high byte returns the top byte of the current capture and, in the same cycle, copies the whole word into a snapshot. The middle and low byte reads then come from that snapshot, so the three bytes always belong to one sample even when new samples are kept between the reads. The interrupt output is the sample-ready bit gated by an enable, and it stays asserted until the host clears the bit with a write-one pulse.

Top module: `wave_decim_capture`

## Requirements
- R1: After reset, sample_ready, irq, host_rdata and fwd_valid are 0. The capture register and the snapshot both read as zero.
- R2: Every cycle with in_valid high produces fwd_valid high in the next cycle, with fwd_data equal to in_data. Otherwise fwd_valid is low in the next cycle. Decimation and host reads never affect this.
- R3: rate_sel value k (0, 1, 2, 3) keeps the first valid sample of each group of 2^k consecutive valid samples. The first valid sample after reset is kept.
- R4: A kept sample becomes the capture, and sample_ready is 1 from the next cycle on.
- R5: irq equals sample_ready AND irq_enable at every cycle.
- R6: A cycle with status_clr high clears sample_ready in the next cycle. If a sample is kept in that same cycle, sample_ready stays 1. Without status_clr, sample_ready never falls.
- R7: A read strobe with host_addr = 2 puts bits 23:16 of the current capture on host_rdata in the next cycle. It also copies the full capture into the snapshot.
- R8: With host_addr = 1, a read returns snapshot bits 15:8 in the next cycle. With host_addr = 0, it returns snapshot bits 7:0. The snapshot changes only on an address-2 read, whatever samples are kept in the meantime.
- R9: A read with host_addr = 3 returns 0x00. host_rdata holds its value in cycles without a read strobe.
- R10: When rate_sel differs from its value in the previous cycle, the decimation phase restarts. A sample valid in that cycle is forwarded but not kept, and the next valid sample is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 24 | Signed ADC sample |
| in_valid | input | 1 | Sample strobe |
| rate_sel | input | 2 | Decimation select: keep 1 of 2^rate_sel samples |
| irq_enable | input | 1 | Interrupt enable |
| status_clr | input | 1 | Write-one pulse that clears sample_ready |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Byte select: 2 high, 1 middle, 0 low |
| host_rdata | output | 8 | Read data, valid the cycle after the strobe |
| sample_ready | output | 1 | Sticky status bit, set when a sample is kept |
| irq | output | 1 | Interrupt request |
| fwd_data | output | 24 | Sample forwarded downstream |
| fwd_valid | output | 1 | Strobe for fwd_data |

## Verification
A wrong decimation phase shows up as a misplaced sample_ready rise. It also shows as a high byte from the wrong sample, and both appear within one group of 2^k valid samples. A snapshot updated at the wrong time shows on the next middle or low byte read as a byte from a newer word. A mishandled clear or set collision shows in the next cycle on sample_ready and irq. A per-cycle reference model compares every output each clock, so each such fault is caught at the first cycle it reaches a port.

// File: rtl/wave_decim_capture.sv
module wave_decim_capture #(
  parameter int SMP_W  = 24,
  parameter int RATE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] in_data,
  input  logic             in_valid,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic             irq_enable,
  input  logic             status_clr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  output logic [7:0]       host_rdata,
  output logic             sample_ready,
  output logic             irq,
  output logic [SMP_W-1:0] fwd_data,
  output logic             fwd_valid
);
  localparam int CNT_W   = (1 << RATE_W) - 1;
  localparam int NBYTES  = SMP_W / 8;
  localparam int HI_ADDR = NBYTES - 1;

  logic [CNT_W-1:0]  cnt, mask;
  logic [RATE_W-1:0] rate_q;
  logic [SMP_W-1:0]  held, snap;
  logic              rate_chg, keep, hi_rd;

  assign mask     = ~({CNT_W{1'b1}} << rate_sel);
  assign rate_chg = rate_sel != rate_q;
  assign keep     = in_valid && !rate_chg && cnt == '0;
  assign hi_rd    = host_rd && int'(host_addr) == HI_ADDR;
  assign irq      = sample_ready & irq_enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= in_valid;
      if (in_valid) fwd_data <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      cnt    <= '0;
    end else begin
      rate_q <= rate_sel;
      if (rate_chg)      cnt <= '0;
      else if (in_valid) cnt <= (cnt + 1'b1) & mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held         <= '0;
      sample_ready <= 1'b0;
    end else begin
      if (keep) held <= in_data;
      if (keep)            sample_ready <= 1'b1;
      else if (status_clr) sample_ready <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap       <= '0;
      host_rdata <= '0;
    end else if (host_rd) begin
      if (hi_rd) begin
        snap       <= held;
        host_rdata <= held[SMP_W-1 -: 8];
      end else if (int'(host_addr) < HI_ADDR) begin
        host_rdata <= snap[host_addr*8 +: 8];
      end else begin
        host_rdata <= 8'h00;
      end
    end
  end

  p_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> fwd_valid && fwd_data == $past(in_data));
  p_fwd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !fwd_valid);
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt & ~mask) == '0 || rate_chg);
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> sample_ready && held == $past(in_data));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ready && !status_clr |=> sample_ready);
  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr && !keep |=> !sample_ready);
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> !irq);
  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd |=> $stable(snap));
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg |=> cnt == '0);
endmodule

// File: tb/sim_wave_decim_capture.sv
module sim_wave_decim_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic [1:0]  rate_sel = '0;
  logic        irq_enable = 1'b0;
  logic        status_clr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [7:0]  host_rdata;
  logic        sample_ready, irq, fwd_valid;
  logic [23:0] fwd_data;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wave_decim_capture u0 (.*);

  // behavioural reference
  int m_cnt = 0, m_prev = 0, m_ready = 0, m_rd = 0, m_pv = 0;
  logic [23:0] m_held = '0, m_snap = '0, m_pd = '0;
  string rd_tag = "R7";

  task automatic cmp(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit chg, kp;
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_prev = 0; m_ready = 0; m_rd = 0; m_pv = 0;
      m_held = '0; m_snap = '0; m_pd = '0;
    end else begin
      chg = int'(rate_sel) != m_prev;
      m_prev = int'(rate_sel);
      kp = in_valid && !chg && m_cnt == 0;             // R3, R10
      if (chg) m_cnt = 0;
      else if (in_valid) m_cnt = (m_cnt + 1) % (1 << rate_sel);
      if (host_rd) begin
        case (host_addr)
          2'd2: begin m_rd = m_held[23:16]; m_snap = m_held; rd_tag = "R7"; end
          2'd1: begin m_rd = m_snap[15:8]; rd_tag = "R8"; end
          2'd0: begin m_rd = m_snap[7:0]; rd_tag = "R8"; end
          default: begin m_rd = 0; rd_tag = "R9"; end
        endcase
      end
      if (kp) m_held = in_data;
      if (kp) m_ready = 1;                              // R4, R6 set wins
      else if (status_clr) m_ready = 0;
      m_pv = in_valid;
      if (in_valid) m_pd = in_data;
    end
    #4;
    if (!rst_n) begin
      cmp("R1 ready", sample_ready, 0);
      cmp("R1 irq", irq, 0);
      cmp("R1 rdata", host_rdata, 0);
      cmp("R1 fwd_valid", fwd_valid, 0);
    end else begin
      cmp("R2 fwd_valid", fwd_valid, m_pv);
      if (m_pv) cmp("R2 fwd_data", fwd_data, m_pd);
      cmp("R4/R6 ready", sample_ready, m_ready);
      cmp("R5 irq", irq, m_ready & irq_enable);
      cmp({rd_tag, " rdata"}, host_rdata, m_rd);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic push(input logic [23:0] d);
    in_data = d; in_valid = 1'b1; tick(); in_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    host_addr = a; host_rd = 1'b1; tick(); host_rd = 1'b0;
  endtask

  initial begin
    repeat (3) tick();                                   // R1 during reset
    rst_n = 1'b1;
    irq_enable = 1'b1;
    tick();
    // R3 rate 0: every sample kept
    push(24'h123456); rd(2); rd(1); rd(0);
    push(24'hFEDCBA); rd(2);
    push(24'h00AA55); rd(1); rd(0);                      // R8 snapshot stays FEDCBA
    rd(3);                                               // R9
    // R6 clear, then set/clear collision
    status_clr = 1'b1; tick(); status_clr = 1'b0; tick();
    in_data = 24'h800001; in_valid = 1'b1; status_clr = 1'b1; tick();
    in_valid = 1'b0; status_clr = 1'b0; tick();
    // R10 rate change with coincident sample
    in_data = 24'h777777; in_valid = 1'b1; rate_sel = 2'd2; tick(); in_valid = 1'b0;
    status_clr = 1'b1; tick(); status_clr = 1'b0;
    for (int i = 0; i < 10; i++) begin push(24'h100 + 24'(i)); rd(2); end
    irq_enable = 1'b0; tick(); irq_enable = 1'b1;        // R5
    // random phase over all rates
    for (int i = 0; i < 4000; i++) begin
      in_data    = 24'($urandom);
      in_valid   = ($urandom % 3) != 0;
      status_clr = ($urandom % 7) == 0;
      host_rd    = ($urandom % 3) == 0;
      host_addr  = 2'($urandom);
      irq_enable = ($urandom % 5) != 0;
      if ($urandom % 200 == 0) rate_sel = 2'($urandom);
      tick();
    end
    in_valid = 1'b0; host_rd = 1'b0; status_clr = 1'b0;
    repeat (3) tick();
    done = 1;
  end

  initial begin
    wait (done || cycles > 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule